// File: doc/BRIEF.md
# Watchdog Supervisor with Paired Clear and Reset-Cause Flags

This block watches the core for a hang. A counter advances on ticks from one of several clock sources. If software does not service it in time, the counter expires. Expiry while the core is running forces a core reset. Expiry while the core is halted wakes it instead.

Servicing takes two separate clear strobes. The counter restarts only once both strobes have arrived since the previous service, in either order. Two flags record why the core restarted: a time-out flag and a power-down flag. Each service clears both flags.

A start-up hold keeps the core in reset for a fixed number of system-clock cycles. The hold applies after power-on, after a watchdog reset and after a wake-up, so that the oscillator can settle.

All timing is taken from the system clock `clk`. The two slow oscillators arrive as single-cycle tick enables that are already synchronised to `clk`. While the core is halted, the system clock counts as stopped, so the divide-by-four source does not advance.

Top module: `wdt_supervisor`

## Requirements
- R1: While `rst_n` is low, `core_rst` is 1 and `to_flag`, `pd_flag` and `wake` are 0. After `rst_n` rises, `core_rst` stays 1 for exactly STARTUP (default 1024) rising edges of `clk` and then falls.
- R2: `src_sel` chooses the watchdog tick:
  - 0 = one tick every fourth `clk` cycle;
  - 1 = `rtc_tick`;
  - 2 = `rc_tick`;
  - 3 = no ticks, so the watchdog is stopped.
  The tick inputs that are not selected have no effect.
- R3: The watchdog expires on the 2^(`pre_sel`+8)-th tick counted from its last restart.
- R4: Expiry while not halted sets `to_flag`, asserts `core_rst` for STARTUP cycles and restarts the count. It leaves `pd_flag` unchanged.
- R5: The count restarts on the edge at which both `clr_a` and `clr_b` have been seen since the previous service. The two may arrive in either order or in the same cycle. Repeating only one of them never restarts the count.
- R6: A completed service clears both `to_flag` and `pd_flag`. Outside of a service, power-on reset, expiry (which sets `to_flag`) and halt entry (which sets `pd_flag`), both flags hold their values.
- R7: A `halt_req` pulse outside the start-up hold sets `pd_flag`, enters halt and zeroes the count. While halted, source 0 does not advance.
- R8: Expiry while halted gives a one-cycle `wake` pulse and sets `to_flag`. It leaves halt and starts a new STARTUP-cycle hold on `core_rst`.
- R9: During the start-up hold the count stays at zero and `halt_req` is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on / external reset, asynchronous, active low |
| src_sel | input | 2 | Watchdog tick source select |
| pre_sel | input | 3 | Time-out exponent select |
| rc_tick | input | 1 | Tick from the internal RC oscillator |
| rtc_tick | input | 1 | Tick from the 32768 Hz oscillator |
| clr_a | input | 1 | First service strobe |
| clr_b | input | 1 | Second service strobe |
| halt_req | input | 1 | Halt entry strobe |
| core_rst | output | 1 | Core reset, active high |
| wake | output | 1 | One-cycle wake-up pulse |
| to_flag | output | 1 | Time-out flag |
| pd_flag | output | 1 | Power-down flag |

## Verification
The assertions check four properties on every cycle:
- the wake pulse lasts one cycle and comes with both flags set and the start-up hold active;
- every rise of the time-out flag coincides with a reset or hold on the core;
- the two flags only ever fall together;
- the power-down flag never rises during the hold.

Only the bench's scenarios can show the exact expiry cycle for each exponent and source, and that unselected ticks are ignored. The same holds for the either-order service rule and the refusal of one repeated strobe. They also show that the divide-by-four source freezes during halt and that the count stays still during the start-up hold.

// File: rtl/wdt_supervisor.sv
module wdt_supervisor #(
  parameter int PRE_BASE = 8,
  parameter int STARTUP  = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] src_sel,
  input  logic [2:0] pre_sel,
  input  logic       rc_tick,
  input  logic       rtc_tick,
  input  logic       clr_a,
  input  logic       clr_b,
  input  logic       halt_req,
  output logic       core_rst,
  output logic       wake,
  output logic       to_flag,
  output logic       pd_flag
);
  localparam int SU_W  = $clog2(STARTUP + 1);
  localparam int CNT_W = PRE_BASE + 8;

  logic [1:0]       div;
  logic             halted, arm_a, arm_b;
  logic [SU_W-1:0]  su_cnt;
  logic [CNT_W-1:0] wcnt;
  logic             tick;

  wire starting = (su_cnt != '0);
  wire div_run  = !starting && !halted;
  wire [4:0] shamt = 5'(pre_sel) + 5'(PRE_BASE);
  wire [CNT_W-1:0] limit = CNT_W'(1) << shamt;
  wire expire = tick && (wcnt == limit - CNT_W'(1));
  wire service = (arm_a | clr_a) & (arm_b | clr_b);

  always_comb begin
    case (src_sel)
      2'd0:    tick = div_run && (div == 2'd3);
      2'd1:    tick = rtc_tick && !starting;
      2'd2:    tick = rc_tick && !starting;
      default: tick = 1'b0;
    endcase
  end

  assign core_rst = !rst_n || starting;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div     <= '0;
      halted  <= 1'b0;
      arm_a   <= 1'b0;
      arm_b   <= 1'b0;
      su_cnt  <= SU_W'(STARTUP);
      wcnt    <= '0;
      to_flag <= 1'b0;
      pd_flag <= 1'b0;
      wake    <= 1'b0;
    end else begin
      wake <= 1'b0;
      div  <= div_run ? div + 2'd1 : 2'd0;
      if (starting) su_cnt <= su_cnt - SU_W'(1);
      if (service) begin
        arm_a   <= 1'b0;
        arm_b   <= 1'b0;
        wcnt    <= '0;
        to_flag <= 1'b0;
        pd_flag <= 1'b0;
      end else begin
        arm_a <= arm_a | clr_a;
        arm_b <= arm_b | clr_b;
        if (expire) begin
          wcnt    <= '0;
          to_flag <= 1'b1;
          su_cnt  <= SU_W'(STARTUP);
          if (halted) begin
            wake   <= 1'b1;
            halted <= 1'b0;
          end
        end else if (halt_req && !starting && !halted) begin
          halted  <= 1'b1;
          pd_flag <= 1'b1;
          wcnt    <= '0;
        end else if (tick) begin
          wcnt <= wcnt + CNT_W'(1);
        end
      end
    end
  end
endmodule

module wdt_supervisor_chk (
  input logic clk,
  input logic rst_n,
  input logic core_rst,
  input logic wake,
  input logic to_flag,
  input logic pd_flag
);
  // R8
  wake_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> !wake);
  // R8
  wake_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> (to_flag && pd_flag && core_rst));
  // R4
  to_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(to_flag) |-> core_rst);
  // R6
  pd_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pd_flag) |-> !to_flag);
  // R6
  to_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(to_flag) |-> !pd_flag);
  // R9
  pd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd_flag) |-> !$past(core_rst));
endmodule

bind wdt_supervisor wdt_supervisor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .core_rst(core_rst),
  .wake(wake), .to_flag(to_flag), .pd_flag(pd_flag)
);

// File: tb/wdt_supervisor_tb.sv
module wdt_supervisor_tb;
  localparam int STARTUP = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] src_sel = 2'd1;
  logic [2:0] pre_sel = 3'd0;
  logic rc_tick = 1'b0, rtc_tick = 1'b1;
  logic clr_a = 1'b0, clr_b = 1'b0, halt_req = 1'b0;
  logic core_rst, wake, to_flag, pd_flag;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  wdt_supervisor #(.PRE_BASE(8), .STARTUP(STARTUP)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .pre_sel(pre_sel),
    .rc_tick(rc_tick), .rtc_tick(rtc_tick), .clr_a(clr_a), .clr_b(clr_b),
    .halt_req(halt_req), .core_rst(core_rst), .wake(wake),
    .to_flag(to_flag), .pd_flag(pd_flag));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wt(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_run();
    int n = 0;
    while (core_rst && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic boot(logic [1:0] s, logic [2:0] p, logic rc, logic rtc);
    @(negedge clk);
    rst_n = 1'b0; src_sel = s; pre_sel = p; rc_tick = rc; rtc_tick = rtc;
    wt(2);
    rst_n = 1'b1;
    wait_run();
  endtask

  task automatic pulse(bit a, bit b, bit h);
    clr_a = a; clr_b = b; halt_req = h;
    @(negedge clk);
    clr_a = 1'b0; clr_b = 1'b0; halt_req = 1'b0;
  endtask

  task automatic expect_expiry(string req, int n);
    wt(n - 1);
    chk({req, " before expiry"}, core_rst, 0);
    wt(1);
    chk({req, " at expiry"}, core_rst, 1);
  endtask

  task automatic t_reset();
    int n = 0;
    @(negedge clk);
    rst_n = 1'b0;
    wt(2);
    chk("R1 core_rst in reset", core_rst, 1);
    chk("R1 flags in reset", {to_flag, pd_flag, wake}, 0);
    rst_n = 1'b1;
    while (core_rst && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk("R1 hold length", n, STARTUP);
  endtask

  task automatic t_timeout();
    boot(2'd1, 3'd0, 1'b0, 1'b1);
    wt(255);
    chk("R3 no expiry at 255", core_rst, 0);
    chk("R4 to_flag before", to_flag, 0);
    wt(1);
    chk("R4 core_rst at 256", core_rst, 1);
    chk("R4 to_flag set", to_flag, 1);
    chk("R4 pd_flag unchanged", pd_flag, 0);
    wait_run();
    wt(100);
    chk("R6 to_flag holds", to_flag, 1);
  endtask

  task automatic t_prescale();
    boot(2'd1, 3'd2, 1'b0, 1'b1);
    expect_expiry("R3 exponent 10", 1024);
    boot(2'd1, 3'd1, 1'b0, 1'b1);
    expect_expiry("R3 exponent 9", 512);
  endtask

  task automatic t_sources();
    boot(2'd0, 3'd0, 1'b0, 1'b0);
    expect_expiry("R2 div4 source", 1024);
    boot(2'd1, 3'd0, 1'b1, 1'b0);
    wt(3000);
    chk("R2 rc ignored when rtc selected", core_rst, 0);
    boot(2'd3, 3'd0, 1'b1, 1'b1);
    wt(3000);
    chk("R2 stopped source", core_rst, 0);
    boot(2'd2, 3'd0, 1'b1, 1'b0);
    expect_expiry("R2 rc source", 256);
  endtask

  task automatic t_single_clear();
    boot(2'd1, 3'd0, 1'b0, 1'b1);
    wt(99);
    pulse(1, 0, 0);
    wt(99);
    pulse(1, 0, 0);
    expect_expiry("R5 repeated clr_a", 56);
  endtask

  task automatic t_dual_clear();
    boot(2'd1, 3'd0, 1'b0, 1'b1);
    wt(256);
    wait_run();
    chk("R6 to_flag before service", to_flag, 1);
    pulse(0, 1, 0);
    wt(50);
    pulse(1, 0, 0);
    chk("R6 to_flag cleared", to_flag, 0);
    expect_expiry("R5 b then a", 256);
    wait_run();
    pulse(1, 1, 0);
    chk("R6 same-cycle clears to_flag", to_flag, 0);
    expect_expiry("R5 same cycle", 256);
  endtask

  task automatic t_halt_div4();
    boot(2'd0, 3'd0, 1'b0, 1'b0);
    wt(10);
    pulse(0, 0, 1);
    chk("R7 pd_flag set", pd_flag, 1);
    wt(3000);
    chk("R7 div4 frozen in halt", {core_rst, wake, to_flag}, 0);
  endtask

  task automatic t_halt_wake();
    boot(2'd1, 3'd0, 1'b0, 1'b1);
    wt(10);
    pulse(0, 0, 1);
    chk("R7 pd_flag on halt", pd_flag, 1);
    wt(255);
    chk("R8 no wake yet", {wake, core_rst}, 0);
    wt(1);
    chk("R8 wake pulse", wake, 1);
    chk("R8 flags on wake", {to_flag, pd_flag}, 3);
    chk("R8 hold after wake", core_rst, 1);
    wt(1);
    chk("R8 wake one cycle", wake, 0);
    wait_run();
    pulse(1, 1, 0);
    chk("R6 service clears both", {to_flag, pd_flag}, 0);
  endtask

  task automatic t_hold_freeze();
    @(negedge clk);
    rst_n = 1'b0; src_sel = 2'd1; pre_sel = 3'd0; rtc_tick = 1'b1; rc_tick = 1'b0;
    wt(2);
    rst_n = 1'b1;
    wt(300);
    pulse(0, 0, 1);
    chk("R9 halt ignored in hold", pd_flag, 0);
    wait_run();
    expect_expiry("R9 count frozen in hold", 256);
  endtask

  initial begin
    t_reset();
    t_timeout();
    t_prescale();
    t_sources();
    t_single_clear();
    t_dual_clear();
    t_halt_div4();
    t_halt_wake();
    t_hold_freeze();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not end)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule